// File: doc/BRIEF.md
# Start-up Option Loader

This block sequences the start of a small 4-bit controller core. While the active-low reset pin is low it keeps the core stopped and clears every configuration byte. When reset is released it first lets the oscillator settle for a programmable number of clocks. It then copies the 64-byte option page at the top of the 8K-byte program memory into a bank of configuration registers.

The program memory is arranged as 4 banks × 32 pages × 64 bytes, and the option page is the last page of the last bank, at addresses 1FC0h–1FFFh. The copy runs inside a fixed window of 512 oscillator clocks. It issues one read every 8 clocks, in ascending address order. The memory returns each byte one clock after its read strobe. When the window closes, the block pulses a program-counter load with the value zero and raises the run enable. The core then executes normally until the next reset.

Top module: `startup_option_loader`

## Requirements
- R1: While rstN is low, cpuRun, pcLoad and memRd are 0 and every byte of optFlat is 0. This takes effect at once, without waiting for a clock edge.
- R2: The release of rstN passes through a two-flop synchroniser. The first memRd appears exactly STAB_CYCLES+3 rising edges after the release.
- R3: No memRd occurs during the stabilisation wait.
- R4: The load phase issues exactly 64 single-cycle memRd strobes, 8 cycles apart. Their addresses rise by one from 1FC0h to 1FFFh.
- R5: The byte on memData in the cycle after a memRd is stored as option byte i, which is optFlat[8*i+7:8*i], where i = memAddr − 1FC0h.
- R6: pcLoad is a one-cycle pulse with pcValue = 0. It occurs exactly 512 rising edges after the first memRd.
- R7: cpuRun rises in the same cycle as pcLoad and stays high while rstN stays high. It is never high before then, and no memRd occurs while it is high.
- R8: A low on rstN at any phase aborts the sequence and clears the option bytes. The next release repeats the whole timing of R2–R7.
- R9: memData is ignored in cycles that do not follow a memRd. Bytes driven there never reach optFlat.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oscillator clock |
| rstN | input | 1 | Asynchronous active-low reset |
| memData | input | 8 | Program-memory read data, valid one cycle after memRd |
| memAddr | output | 13 | Program-memory read address |
| memRd | output | 1 | Program-memory read strobe |
| optFlat | output | 512 | Option bytes, byte i at bits 8*i+7..8*i |
| pcLoad | output | 1 | One-cycle program-counter load pulse |
| pcValue | output | 13 | Program-counter load value (zero) |
| cpuRun | output | 1 | Core run enable |

## Verification
Complete boots run with a different random memory image each time. Because the content changes between boots, a wrong address-to-slot mapping or stale bytes from an earlier boot show up as byte mismatches. Outside the read-return cycles, memData carries random noise, so any capture taken at the wrong cycle corrupts optFlat. Resets are injected at random points in the stabilisation, load and run phases. After each one, the bench checks that the outputs clear at once and that the following boot keeps exact cycle timing, which separates a true restart from a resumed count.

// File: rtl/startup_option_pkg.sv
package startup_option_pkg;
  typedef enum logic [1:0] {
    PH_HOLD,
    PH_STAB,
    PH_LOAD,
    PH_RUN
  } phase_t;

  typedef struct packed {
    logic clear;
    logic fetch;
  } strobe_t;
endpackage

// File: rtl/startup_option_ctrl.sv
module startup_option_ctrl
  import startup_option_pkg::*;
#(
  parameter int STAB_CYCLES = 4096,
  parameter int LOAD_CYCLES = 512,
  parameter int SLOTS       = 64,
  parameter int STRIDE      = 8
) (
  input  logic                      clk,
  input  logic                      rstN,
  output strobe_t                   strobe,
  output logic [$clog2(SLOTS)-1:0]  slot,
  output logic                      pcLoad,
  output logic                      cpuRun
);
  localparam int MAX_CYC  = (STAB_CYCLES > LOAD_CYCLES) ? STAB_CYCLES : LOAD_CYCLES;
  localparam int CNT_W    = $clog2(MAX_CYC + 1);
  localparam int SLOT_W   = $clog2(SLOTS);
  localparam int STRIDE_W = $clog2(STRIDE);

  logic [1:0]       syncQ;
  logic             relN;
  phase_t           phase;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] slotWide;

  // Asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) syncQ <= '0;
    else       syncQ <= {syncQ[0], 1'b1};
  end
  assign relN = syncQ[1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase  <= PH_HOLD;
      cnt    <= '0;
      pcLoad <= 1'b0;
    end else begin
      pcLoad <= 1'b0;
      case (phase)
        PH_HOLD: if (relN) begin
          phase <= PH_STAB;
          cnt   <= '0;
        end
        PH_STAB: if (cnt == CNT_W'(STAB_CYCLES - 1)) begin
          phase <= PH_LOAD;
          cnt   <= '0;
        end else begin
          cnt <= cnt + 1'b1;
        end
        PH_LOAD: if (cnt == CNT_W'(LOAD_CYCLES - 1)) begin
          phase  <= PH_RUN;
          pcLoad <= 1'b1;
          cnt    <= '0;
        end else begin
          cnt <= cnt + 1'b1;
        end
        default: phase <= PH_RUN;
      endcase
    end
  end

  assign slotWide     = cnt >> STRIDE_W;
  assign slot         = SLOT_W'(slotWide);
  assign strobe.fetch = (phase == PH_LOAD) && (cnt[STRIDE_W-1:0] == '0)
                        && (slotWide < CNT_W'(SLOTS));
  assign strobe.clear = (phase == PH_HOLD);
  assign cpuRun       = (phase == PH_RUN);
endmodule

// File: rtl/startup_option_dp.sv
module startup_option_dp
  import startup_option_pkg::*;
#(
  parameter int             ADDR_W = 13,
  parameter int             DATA_W = 8,
  parameter int             SLOTS  = 64,
  parameter logic [12:0]    BASE   = 13'h1FC0
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  strobe_t                    strobe,
  input  logic [$clog2(SLOTS)-1:0]   slot,
  input  logic [DATA_W-1:0]          memData,
  output logic [ADDR_W-1:0]          memAddr,
  output logic                       memRd,
  output logic [SLOTS*DATA_W-1:0]    optFlat
);
  localparam int SLOT_W = $clog2(SLOTS);

  logic              capValid;
  logic [SLOT_W-1:0] capSlot;

  assign memRd   = strobe.fetch;
  assign memAddr = ADDR_W'(BASE) + ADDR_W'(slot);

  // Remember which slot the returning byte belongs to
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      capValid <= 1'b0;
      capSlot  <= '0;
    end else begin
      capValid <= strobe.fetch;
      capSlot  <= slot;
    end
  end

  for (genvar i = 0; i < SLOTS; i++) begin : gSlot
    logic [DATA_W-1:0] optReg;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                                        optReg <= '0;
      else if (strobe.clear)                            optReg <= '0;
      else if (capValid && capSlot == SLOT_W'(i))       optReg <= memData;
    end
    assign optFlat[i*DATA_W +: DATA_W] = optReg;
  end
endmodule

// File: rtl/startup_option_loader.sv
module startup_option_loader
  import startup_option_pkg::*;
#(
  parameter int          STAB_CYCLES = 4096,
  parameter int          LOAD_CYCLES = 512,
  parameter int          SLOTS       = 64,
  parameter int          STRIDE      = 8,
  parameter int          ADDR_W      = 13,
  parameter int          DATA_W      = 8,
  parameter logic [12:0] BASE        = 13'h1FC0
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic [DATA_W-1:0]       memData,
  output logic [ADDR_W-1:0]       memAddr,
  output logic                    memRd,
  output logic [SLOTS*DATA_W-1:0] optFlat,
  output logic                    pcLoad,
  output logic [ADDR_W-1:0]       pcValue,
  output logic                    cpuRun
);
  strobe_t                   strobe;
  logic [$clog2(SLOTS)-1:0]  slot;

  startup_option_ctrl #(
    .STAB_CYCLES(STAB_CYCLES), .LOAD_CYCLES(LOAD_CYCLES),
    .SLOTS(SLOTS), .STRIDE(STRIDE)
  ) ctrl (
    .clk(clk), .rstN(rstN), .strobe(strobe), .slot(slot),
    .pcLoad(pcLoad), .cpuRun(cpuRun)
  );

  startup_option_dp #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SLOTS(SLOTS), .BASE(BASE)
  ) dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .slot(slot), .memData(memData),
    .memAddr(memAddr), .memRd(memRd), .optFlat(optFlat)
  );

  assign pcValue = '0;
endmodule

// File: rtl/startup_option_chk.sv
module startup_option_chk #(
  parameter int          ADDR_W = 13,
  parameter logic [12:0] BASE   = 13'h1FC0
) (
  input logic              clk,
  input logic              rstN,
  input logic              cpuRun,
  input logic              pcLoad,
  input logic              memRd,
  input logic [ADDR_W-1:0] memAddr
);
  assert_rd_single_R4: assert property (@(posedge clk) disable iff (!rstN)
    memRd |=> !memRd);

  assert_rd_region_R4: assert property (@(posedge clk) disable iff (!rstN)
    memRd |-> memAddr >= ADDR_W'(BASE));

  assert_pc_pulse_R6: assert property (@(posedge clk) disable iff (!rstN)
    pcLoad |=> !pcLoad);

  assert_run_start_R7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(cpuRun) |-> pcLoad);

  assert_pc_with_run_R7: assert property (@(posedge clk) disable iff (!rstN)
    pcLoad |-> cpuRun);

  assert_run_sticky_R7: assert property (@(posedge clk) disable iff (!rstN)
    cpuRun |=> cpuRun);

  assert_run_no_read_R7: assert property (@(posedge clk) disable iff (!rstN)
    cpuRun |-> !memRd);
endmodule

bind startup_option_loader startup_option_chk #(.ADDR_W(ADDR_W), .BASE(BASE)) chkInst (
  .clk(clk), .rstN(rstN), .cpuRun(cpuRun), .pcLoad(pcLoad),
  .memRd(memRd), .memAddr(memAddr)
);

// File: tb/startup_option_loader_test.sv
module startup_option_loader_test;
  localparam int S       = 4096;
  localparam int BOOTLEN = S + 3 + 512;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic [7:0]   memData;
  logic [12:0]  memAddr;
  logic         memRd;
  logic [511:0] optFlat;
  logic         pcLoad;
  logic [12:0]  pcValue;
  logic         cpuRun;
  logic [7:0]   salt = 8'h00;
  int           vectors = 0;
  int           miscompares = 0;

  always #4 clk = ~clk;

  startup_option_loader uut (
    .clk(clk), .rstN(rstN), .memData(memData), .memAddr(memAddr), .memRd(memRd),
    .optFlat(optFlat), .pcLoad(pcLoad), .pcValue(pcValue), .cpuRun(cpuRun)
  );

  function automatic logic [7:0] byteAt(input logic [12:0] a, input logic [7:0] s);
    return 8'(a[7:0] * 8'd29) ^ s ^ {3'b000, a[12:8]};
  endfunction

  // Memory model: one-cycle read latency, noise otherwise (R9)
  always @(posedge clk) begin
    if (memRd) memData <= byteAt(memAddr, salt);
    else       memData <= 8'($urandom);
  end

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic checkCleared(input string req);
    check(cpuRun == 1'b0, {req, " cpuRun"}, cpuRun, 0);
    check(memRd == 1'b0, {req, " memRd"}, memRd, 0);
    check(pcLoad == 1'b0, {req, " pcLoad"}, pcLoad, 0);
    check(optFlat == '0, {req, " optFlat"}, longint'(optFlat[63:0]), 0);
  endtask

  // Full boot from release to normal run, cycle-exact
  task automatic runBoot(input logic [7:0] s);
    int firstRd = S + 3;
    salt = s;
    @(negedge clk);
    rstN = 1'b1;
    for (int n = 1; n <= BOOTLEN + 4; n++) begin
      @(posedge clk);
      @(negedge clk);
      begin
        int  rel = n - firstRd;
        bit  expRd = (rel >= 0) && (rel % 8 == 0) && (rel / 8 < 64);
        if (n < firstRd) begin
          if (memRd) check(1'b0, "R3 read during wait", n, firstRd);
        end else if (expRd) begin
          check(memRd == 1'b1, "R2 R4 memRd strobe", memRd, 1);
          check(memAddr == 13'h1FC0 + 13'(rel / 8), "R4 memAddr", memAddr, 13'h1FC0 + rel / 8);
        end else if (memRd) begin
          check(1'b0, "R4 extra read", n, 0);
        end
        if (pcLoad != (n == BOOTLEN)) check(1'b0, "R6 pcLoad timing", n, BOOTLEN);
        if (n == BOOTLEN) check(pcValue == 13'h0, "R6 pcValue", pcValue, 0);
        if (cpuRun != (n >= BOOTLEN)) check(1'b0, "R7 cpuRun timing", n, BOOTLEN);
      end
    end
    check(cpuRun == 1'b1, "R7 running", cpuRun, 1);
    for (int i = 0; i < 64; i++) begin
      logic [7:0] exp = byteAt(13'h1FC0 + 13'(i), s);
      check(optFlat[8*i +: 8] == exp, "R5 R9 option byte", optFlat[8*i +: 8], exp);
    end
  endtask

  task automatic abortAt(input int k);
    @(negedge clk);
    rstN = 1'b1;
    repeat (k) @(posedge clk);
    @(negedge clk);
    #1 rstN = 1'b0;
    #1 checkCleared("R1 R8 abort");
    repeat (5) begin
      @(negedge clk);
      check(memRd == 1'b0 && cpuRun == 1'b0, "R1 held", {memRd, cpuRun}, 0);
    end
  endtask

  initial begin
    #(8 * 200000);
    miscompares++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    void'($urandom(32'h5A17));
    repeat (4) @(negedge clk);
    checkCleared("R1 reset state");
    runBoot(8'h3C);
    // reset while running
    @(negedge clk);
    #1 rstN = 1'b0;
    #1 checkCleared("R8 reset from run");
    repeat (3) @(negedge clk);
    // corners: abort in sync, in stab, at first read, late in load
    abortAt(1);
    abortAt(S / 2);
    abortAt(S + 3);
    abortAt(S + 3 + 505);
    runBoot(8'hA5);
    @(negedge clk);
    #1 rstN = 1'b0;
    repeat (3) @(negedge clk);
    for (int r = 0; r < 3; r++) begin
      abortAt($urandom_range(S + 514, 1));
      runBoot(8'($urandom));
      @(negedge clk);
      #1 rstN = 1'b0;
      #1 checkCleared("R8 random restart");
      repeat (2) @(negedge clk);
    end
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule